// File: doc/BRIEF.md
# Sensor ADC host read controller

This block is the host-side sequencer for a serial temperature/voltage converter. The converter takes command bytes on a data-in line and returns results on a data-out line. A caller hands over one conversion request. The block lowers chip select and sends a configuration byte, but only when the reference setting has changed since the last one it sent. It then sends the conversion byte. While the converter works, the block holds the serial clock low and waits for the converter's ready strobe to rise. After that it clocks in a 16-bit frame. It returns a 12-bit result, whose unpacking depends on whether the frame holds a temperature or a voltage.

The serial clock comes from an internal divider, with a half-period of `HALF_CLKS` system clocks. The request side is a valid/ready pair: `req_ready` is high only while the block is idle, and a request is taken on a cycle where both `req_valid` and `req_ready` are high. While a transaction is open, a valid request is not taken and is dropped; the caller must hold or repeat it. The result side has no back-pressure. `res_valid` is a one-cycle pulse, and `res_data`/`res_temp` hold their value until the next result. If the strobe never rises, a wait limit ends the transaction with an error pulse.

Top module: `sensor_adc_reader`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk`, `busy`, `res_valid` and `err_timeout` are 0, and `req_ready` is 1.
- R2: `sclk` toggles every `HALF_CLKS` system clocks while bits move. `din` changes only while `sclk` is low, so it is stable at every rising `sclk` edge.
- R3: A configuration byte `{2'b10, zeros, req_ref}` is shifted out, MSB first, ahead of the conversion byte. This happens only on the first request after reset or when `req_ref` differs from the value last sent.
- R4: Every accepted request sends the conversion byte `{2'b11, req_chan}`, MSB first. Bit 6 set marks it as a conversion byte.
- R5: Once the conversion byte has ended, `sclk` stays low for as long as `sstrb` is low.
- R6: After `sstrb` rises, exactly 16 rising `sclk` edges are issued. `dout` is sampled at each one, and the first sample is the MSB.
- R7: For a temperature request (`req_temp`=1), `res_data` is frame bits 13..2 and `res_temp` is 1.
- R8: For a voltage request (`req_temp`=0), `res_data` is frame bits 15..4 as two's complement and `res_temp` is 0.
- R9: `cs_n` rises `HALF_CLKS` clocks after the last falling `sclk` edge. `res_valid` pulses for one cycle in that same cycle.
- R10: If `sstrb` has not risen `WAIT_LIMIT` clocks after the conversion byte's last falling edge, `err_timeout` pulses, `cs_n` rises, `busy` falls and no `res_valid` is given.
- R11: `busy` is high from the accepting cycle until the result or error pulse, and `req_ready` is its inverse. A request that arrives while busy starts no transfer and changes no later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Conversion request present |
| req_ready | output | 1 | Block can take a request (idle) |
| req_ref | input | REF_W | Reference setting for this conversion |
| req_chan | input | 6 | Conversion selector bits placed in the conversion byte |
| req_temp | input | 1 | 1: temperature frame, 0: voltage frame |
| res_valid | output | 1 | One-cycle result pulse |
| res_data | output | 12 | Unpacked result |
| res_temp | output | 1 | Frame type of the result |
| busy | output | 1 | Transaction open |
| err_timeout | output | 1 | One-cycle pulse when the strobe wait expires |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock |
| din | output | 1 | Serial data to the converter |
| dout | input | 1 | Serial data from the converter |
| sstrb | input | 1 | Converter ready strobe, high when the result is available |

## Verification
A stale reference cache shows at the ports within one transaction. It appears as an extra or missing configuration byte before the conversion byte. A wrong bit counter shows as a byte of the wrong length, which a converter model would decode as garbage, or as a frame of 15 or 17 clocks. Either one moves the chip-select release and shifts the unpacked result by a bit. A divider or hold error shows on the first `sclk` edge, or in the spacing between the last falling edge and `cs_n`. A wait state that leaks clocks shows as an `sclk` edge while the strobe is low, as soon as the conversion starts.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int BYTE_W  = 8;
  localparam int CHAN_W  = BYTE_W - 2;
  localparam int FRAME_W = 16;
  localparam int RES_W   = 12;
  localparam int TEMP_LSB = 2;
  localparam int VOLT_LSB = FRAME_W - RES_W;
  localparam logic [1:0] CFG_TAG  = 2'b10;
  localparam logic [1:0] CONV_TAG = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_TX,
    ST_WAIT,
    ST_RX,
    ST_HOLD
  } sar_state_e;
endpackage

// File: rtl/sar_half_tick.sv
module sar_half_tick #(
  parameter int HALF_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt;

  always_comb tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  p_tick_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick);
endmodule

// File: rtl/sar_tx_shift.sv
module sar_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (clear) sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign msb = sr[W-1];
endmodule

// File: rtl/sar_rx_capture.sv
module sar_rx_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         sample,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)      word <= '0;
    else if (clear)  word <= '0;
    else if (sample) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/sar_frame_unpack.sv
module sar_frame_unpack
  import sar_pkg::*;
(
  input  logic [FRAME_W-1:0] frame,
  input  logic               is_temp,
  output logic [RES_W-1:0]   value
);
  always_comb begin
    if (is_temp) value = frame[TEMP_LSB +: RES_W];
    else         value = frame[VOLT_LSB +: RES_W];
  end
endmodule

// File: rtl/sensor_adc_reader.sv
module sensor_adc_reader
  import sar_pkg::*;
#(
  parameter int HALF_CLKS  = 2,
  parameter int WAIT_LIMIT = 3000,
  parameter int REF_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [REF_W-1:0]  req_ref,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic              req_temp,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic              res_temp,
  output logic              busy,
  output logic              err_timeout,
  output logic              cs_n,
  output logic              sclk,
  output logic              din,
  input  logic              dout,
  input  logic              sstrb
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam int TO_W  = $clog2(WAIT_LIMIT + 1);
  localparam logic [BIT_W-1:0] LAST_TX = BIT_W'(BYTE_W - 1);
  localparam logic [BIT_W-1:0] LAST_RX = BIT_W'(FRAME_W - 1);
  localparam logic [TO_W-1:0]  TO_LAST = TO_W'(WAIT_LIMIT - 1);

  sar_state_e         state;
  logic               sclk_r, cs_n_r, sstrb_q;
  logic               cfg_known, send_cfg, temp_q;
  logic [REF_W-1:0]   last_ref;
  logic [BYTE_W-1:0]  conv_q;
  logic [BIT_W-1:0]   bitcnt;
  logic [TO_W-1:0]    to_cnt;
  logic               res_valid_r, err_r, res_temp_r;
  logic [RES_W-1:0]   res_data_r;

  logic               tick, tick_en, accept, need_cfg, strobe_rise;
  logic [BYTE_W-1:0]  cfg_byte, conv_now, tx_val;
  logic               tx_load, tx_shift, tx_clear, tx_msb;
  logic               rx_sample;
  logic [FRAME_W-1:0] rx_word;
  logic [RES_W-1:0]   unpacked;

  assign accept      = req_valid && (state == ST_IDLE);
  assign need_cfg    = !cfg_known || (req_ref != last_ref);
  assign cfg_byte    = {CFG_TAG, {(CHAN_W - REF_W){1'b0}}, req_ref};
  assign conv_now    = {CONV_TAG, req_chan};
  assign strobe_rise = sstrb && !sstrb_q;
  assign tick_en     = (state == ST_SETUP) || (state == ST_TX) ||
                       (state == ST_RX) || (state == ST_HOLD);
  assign rx_sample   = (state == ST_RX) && tick && !sclk_r;

  always_comb begin
    tx_load  = 1'b0;
    tx_shift = 1'b0;
    tx_clear = 1'b0;
    tx_val   = conv_q;
    if (accept) begin
      tx_load = 1'b1;
      tx_val  = need_cfg ? cfg_byte : conv_now;
    end else if (state == ST_TX && tick && sclk_r) begin
      if (bitcnt == LAST_TX) begin
        if (send_cfg) tx_load  = 1'b1;
        else          tx_clear = 1'b1;
      end else begin
        tx_shift = 1'b1;
      end
    end
  end

  sar_half_tick #(.HALF_CLKS(HALF_CLKS)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(tick_en), .tick(tick)
  );

  sar_tx_shift #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clear(tx_clear), .load(tx_load),
    .load_val(tx_val), .shift(tx_shift), .msb(tx_msb)
  );

  sar_rx_capture #(.W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(rx_sample),
    .bit_in(dout), .word(rx_word)
  );

  sar_frame_unpack u_unpack (
    .frame(rx_word), .is_temp(temp_q), .value(unpacked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      sclk_r      <= 1'b0;
      cs_n_r      <= 1'b1;
      sstrb_q     <= 1'b1;
      cfg_known   <= 1'b0;
      send_cfg    <= 1'b0;
      temp_q      <= 1'b0;
      last_ref    <= '0;
      conv_q      <= '0;
      bitcnt      <= '0;
      to_cnt      <= '0;
      res_valid_r <= 1'b0;
      err_r       <= 1'b0;
      res_temp_r  <= 1'b0;
      res_data_r  <= '0;
    end else begin
      res_valid_r <= 1'b0;
      err_r       <= 1'b0;
      sstrb_q     <= sstrb;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cs_n_r    <= 1'b0;
            send_cfg  <= need_cfg;
            conv_q    <= conv_now;
            temp_q    <= req_temp;
            cfg_known <= 1'b1;
            last_ref  <= req_ref;
            bitcnt    <= '0;
            state     <= ST_SETUP;
          end
        end
        ST_SETUP: if (tick) state <= ST_TX;
        ST_TX: begin
          if (tick) begin
            if (!sclk_r) begin
              sclk_r <= 1'b1;
            end else begin
              sclk_r <= 1'b0;
              if (bitcnt == LAST_TX) begin
                bitcnt <= '0;
                if (send_cfg) begin
                  send_cfg <= 1'b0;
                end else begin
                  to_cnt <= '0;
                  state  <= ST_WAIT;
                end
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
        end
        ST_WAIT: begin
          if (strobe_rise) begin
            state <= ST_RX;
          end else if (to_cnt == TO_LAST) begin
            err_r  <= 1'b1;
            cs_n_r <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            to_cnt <= to_cnt + 1'b1;
          end
        end
        ST_RX: begin
          if (tick) begin
            if (!sclk_r) begin
              sclk_r <= 1'b1;
            end else begin
              sclk_r <= 1'b0;
              if (bitcnt == LAST_RX) state  <= ST_HOLD;
              else                   bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (tick) begin
            cs_n_r      <= 1'b1;
            res_valid_r <= 1'b1;
            res_data_r  <= unpacked;
            res_temp_r  <= temp_q;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign req_ready   = (state == ST_IDLE);
  assign cs_n        = cs_n_r;
  assign sclk        = sclk_r;
  assign din         = tx_msb;
  assign res_valid   = res_valid_r;
  assign res_data    = res_data_r;
  assign res_temp    = res_temp_r;
  assign err_timeout = err_r;

  // Checker state: rising serial-clock edges since the strobe wait.
  logic [BIT_W:0] a_rx_rises;
  logic           a_sclk_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rx_rises <= '0;
      a_sclk_d   <= 1'b0;
    end else begin
      a_sclk_d <= sclk_r;
      if (state == ST_WAIT)                       a_rx_rises <= '0;
      else if (sclk_r && !a_sclk_d && cs_n_r == 1'b0 &&
               (state == ST_RX || state == ST_HOLD)) a_rx_rises <= a_rx_rises + 1'b1;
    end
  end

  p_din_stable_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && $past(sclk)) |-> $stable(din));
  p_sclk_parked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !sstrb_q) |-> !sclk);
  p_sixteen_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (a_rx_rises == (BIT_W+1)'(FRAME_W)));
  p_cs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (cs_n && !$past(cs_n)));
  p_end_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && err_timeout));
  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  p_cs_only_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
endmodule

// File: tb/sensor_adc_reader_bench.sv
module sensor_adc_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int LIMIT      = 3000;
  localparam int CONV_WAIT  = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_ref = '0;
  logic [5:0] req_chan = '0;
  logic req_temp = 1'b0;
  logic res_valid, res_temp, busy, err_timeout, cs_n, sclk, din, dout;
  logic [11:0] res_data;
  logic sstrb = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_adc_reader #(.HALF_CLKS(HALF), .WAIT_LIMIT(LIMIT), .REF_W(2)) u_sensor_adc_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ref(req_ref), .req_chan(req_chan), .req_temp(req_temp),
    .res_valid(res_valid), .res_data(res_data), .res_temp(res_temp),
    .busy(busy), .err_timeout(err_timeout), .cs_n(cs_n), .sclk(sclk),
    .din(din), .dout(dout), .sstrb(sstrb)
  );

  // ---------------- converter model ----------------
  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  logic [15:0] adc_word = '0;
  logic stuck = 1'b0;
  logic out_mode = 1'b0;
  int out_idx = 0;
  logic [7:0] rx_byte = '0;
  int rx_bits = 0;
  int cfg_cnt = 0, conv_cnt = 0, conv_served = 0;
  logic [7:0] last_cfg = '0, last_conv = '0;
  int out_clocks = 0, strobe_viol = 0, din_viol = 0;
  int t_fall = 0, t_csrise = 0;

  assign dout = (out_mode && out_idx < 16) ? adc_word[15 - out_idx] : 1'b0;

  always @(posedge sclk) if (!cs_n) begin
    if (!sstrb) strobe_viol = strobe_viol + 1;
    if (out_mode) out_clocks = out_clocks + 1;
    else begin
      rx_byte = {rx_byte[6:0], din};
      rx_bits = rx_bits + 1;
    end
  end

  always @(negedge sclk) begin
    t_fall = cyc;
    if (!cs_n) begin
      if (out_mode) out_idx = out_idx + 1;
      else begin
        out_idx = 0;
        if (rx_bits == 8) begin
          rx_bits = 0;
          if (rx_byte[6]) begin conv_cnt = conv_cnt + 1; last_conv = rx_byte; end
          else begin cfg_cnt = cfg_cnt + 1; last_cfg = rx_byte; end
        end
      end
    end
  end

  always @(posedge cs_n) t_csrise = cyc;
  always @(din) if (!cs_n && sclk) din_viol = din_viol + 1;

  always @(negedge clk) begin
    if (conv_cnt != conv_served) begin
      conv_served = conv_cnt;
      sstrb = 1'b0;
      repeat (CONV_WAIT) @(negedge clk);
      if (!stuck) begin
        out_mode = 1'b1;
        sstrb = 1'b1;
        @(posedge cs_n);
        out_mode = 1'b0;
      end else begin
        @(posedge cs_n);
        sstrb = 1'b1;
      end
    end
  end

  // ---------------- checking ----------------
  int vectors = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] rf, input logic [5:0] ch, input logic tp);
    @(negedge clk);
    req_valid = 1'b1; req_ref = rf; req_chan = ch; req_temp = tp;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end(output bit got_res, output bit got_err);
    got_res = 0; got_err = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (res_valid) begin got_res = 1; break; end
      if (err_timeout) begin got_err = 1; break; end
    end
  endtask

  task automatic t_reset;
    check(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
    check(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
    check(busy == 1'b0 && req_ready == 1'b1, "R1 busy/ready", int'({busy, req_ready}), 1);
    check(res_valid == 1'b0 && err_timeout == 1'b0, "R1 pulses", int'({res_valid, err_timeout}), 0);
  endtask

  // one full transaction with expected config-byte behaviour and result
  task automatic t_xfer(input string tag, input logic [1:0] rf, input logic [5:0] ch,
                        input logic tp, input logic [11:0] val, input bit expect_cfg);
    int cfg0, conv0, oc0, sv0, dv0;
    bit gr, ge;
    logic [7:0] exp_conv;
    cfg0 = cfg_cnt; conv0 = conv_cnt; oc0 = out_clocks; sv0 = strobe_viol; dv0 = din_viol;
    if (tp) adc_word = {2'b01, val, 2'b00};
    else    adc_word = {val, 4'b1000};
    exp_conv = {2'b11, ch};
    issue(rf, ch, tp);
    wait_end(gr, ge);
    check(gr && !ge, {tag, " R9 result pulse"}, int'({gr, ge}), 2);
    check(cfg_cnt - cfg0 == (expect_cfg ? 1 : 0), {tag, " R3 config byte count"}, cfg_cnt - cfg0, expect_cfg ? 1 : 0);
    if (expect_cfg)
      check(last_cfg == {6'b100000, rf}, {tag, " R3 config byte"}, int'(last_cfg), int'({6'b100000, rf}));
    check(conv_cnt - conv0 == 1 && last_conv == exp_conv, {tag, " R4 conversion byte"}, int'(last_conv), int'(exp_conv));
    check(out_clocks - oc0 == 16, {tag, " R6 frame clocks"}, out_clocks - oc0, 16);
    check(strobe_viol == sv0, {tag, " R5 sclk while strobe low"}, strobe_viol - sv0, 0);
    check(din_viol == dv0, {tag, " R2 din change while sclk high"}, din_viol - dv0, 0);
    if (tp) check(res_data == val && res_temp, {tag, " R7 temperature unpack"}, int'({res_temp, res_data}), int'({1'b1, val}));
    else    check(res_data == val && !res_temp, {tag, " R8 voltage unpack"}, int'({res_temp, res_data}), int'({1'b0, val}));
    check(t_csrise - t_fall == HALF, {tag, " R9 cs hold"}, t_csrise - t_fall, HALF);
    check(!busy && req_ready && cs_n, {tag, " R11 idle after result"}, int'({busy, req_ready, cs_n}), 3);
  endtask

  task automatic t_busy_ignored;
    int conv0, cfg0;
    bit gr, ge;
    conv0 = conv_cnt; cfg0 = cfg_cnt;
    adc_word = {2'b00, 12'h5A3, 2'b00};
    issue(2'b10, 6'h03, 1'b1);
    repeat (30) @(negedge clk);
    check(req_ready == 1'b0 && busy, "R11 ready low while busy", int'({busy, req_ready}), 2);
    req_valid = 1'b1; req_ref = 2'b00; req_chan = 6'h3F; req_temp = 1'b0;
    repeat (60) @(negedge clk);
    req_valid = 1'b0;
    wait_end(gr, ge);
    check(gr && res_data == 12'h5A3 && res_temp, "R11 result of first request", int'({res_temp, res_data}), int'({1'b1, 12'h5A3}));
    check(last_conv == 8'hC3 && cfg_cnt == cfg0, "R11 busy request sent nothing", int'(last_conv), 8'hC3);
    repeat (40) @(negedge clk);
    check(conv_cnt - conv0 == 1 && !busy && cs_n, "R11 no deferred transfer", conv_cnt - conv0, 1);
  endtask

  task automatic t_timeout;
    bit gr, ge;
    int tf;
    stuck = 1'b1;
    issue(2'b10, 6'h11, 1'b0);
    wait_end(gr, ge);
    tf = t_fall;
    check(ge && !gr, "R10 error pulse instead of result", int'({gr, ge}), 1);
    check(cyc - tf == LIMIT, "R10 wait limit", cyc - tf, LIMIT);
    check(cs_n && !busy && req_ready, "R10 released after error", int'({cs_n, busy, req_ready}), 5);
    stuck = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_xfer("first temp", 2'b01, 6'h15, 1'b1, 12'hA6C, 1'b1);
    t_xfer("same ref volt", 2'b01, 6'h0A, 1'b0, 12'hF38, 1'b0);
    t_xfer("ref change", 2'b10, 6'h2E, 1'b1, 12'h001, 1'b1);
    t_xfer("volt max", 2'b10, 6'h00, 1'b0, 12'h7FF, 1'b0);
    t_busy_ignored();
    t_timeout();
    t_xfer("after timeout", 2'b10, 6'h21, 1'b0, 12'h800, 1'b0);
    t_xfer("ref back", 2'b01, 6'h3F, 1'b1, 12'hFFF, 1'b1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors + 1, fails + 1);
    $finish;
  end
endmodule